// File: doc/BRIEF.md
# Programmable Three-Port Parallel Interface

This block gives a host three byte-wide parallel ports and one command register behind a small asynchronous-style bus. The bus has an active-low select, separate active-low read and write strobes, a two-bit register address and byte-wide data. Each port presents an output value, an output enable and an input value, so the pads outside the block can be built as tri-state pins. Port C is split into two nibbles, and each nibble has its own direction.

The command register accepts two formats, and bit 7 tells them apart. A direction word (bit 7 set) decides which ports drive and which listen. It also clears every output latch. A bit command (bit 7 clear) sets or clears one port C bit and leaves every other bit alone. The bits that would pick a handshaking mode are stored and can be read back, but they have no effect: the block always behaves as plain I/O.

Writes are sampled on each rising clock edge while select and write are both low, so a strobe held for several cycles writes the same value again and nothing changes. Reads are combinational while select and read are both low.

Top module: `tri_port_pio`

## Requirements
- R1: While `rst` is high, and after it falls until the next command write, every output enable is low, every output latch is 0, and a read of address 3 returns 9Bh.
- R2: When `csN` is low, `addr` picks the target: 0 is port A, 1 is port B, 2 is port C and 3 is the command register. A port write stores `dataIn` in that port's latch only.
- R3: When `csN` is high, writes change nothing and `dataOe` stays low. `dataOe` is high exactly when `csN` and `rdN` are low and `wrN` is high.
- R4: A write to address 3 with bit 7 = 1 sets the directions, with 1 meaning input: bit 4 for port A, bit 3 for port C bits 7..4, bit 1 for port B and bit 0 for port C bits 3..0. A port or nibble set to output drives all its enables high; one set to input drives them all low. So 80h makes every port an output, 82h makes only port B an input, 83h makes port B and the low nibble of C inputs, and 90h makes only port A an input.
- R5: A direction word clears the latches of ports A, B and C to 0.
- R6: A write to address 3 with bit 7 = 0 copies bit 0 into the port C bit whose index is given by bits 3..1. All other port C bits stay unchanged, and the command register readback stays unchanged.
- R7: A read of a port or nibble set to output returns its latch. A read of one set to input returns its input pins. The two nibbles of port C are resolved separately.
- R8: A read of address 3 returns the last direction word written, all 8 bits.
- R9: Bits 6, 5 and 2 of a direction word have no effect on directions, latches or reads of ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| csN | input | 1 | Block select, active low |
| rdN | input | 1 | Read strobe, active low |
| wrN | input | 1 | Write strobe, active low |
| addr | input | 2 | Register address |
| dataIn | input | 8 | Write data from host |
| dataOut | output | 8 | Read data to host |
| dataOe | output | 1 | Read data valid / bus drive enable |
| paOut | output | 8 | Port A latch value |
| paOe | output | 8 | Port A drive enables |
| paIn | input | 8 | Port A pin values |
| pbOut | output | 8 | Port B latch value |
| pbOe | output | 8 | Port B drive enables |
| pbIn | input | 8 | Port B pin values |
| pcOut | output | 8 | Port C latch value |
| pcOe | output | 8 | Port C drive enables |
| pcIn | input | 8 | Port C pin values |

## Verification
Every one of the 128 direction words with bit 7 set is written in turn. For each word the bench checks the enables, the readback and the cleared latches. It then writes distinct data patterns to each port while the pins carry different patterns. Because the two patterns differ, a read shows whether the latch or the pin was returned, and it does so separately for each port and each C nibble. It also shows if a direction bit was wired to the wrong port or if the handshake bits leak into behaviour. Every bit index and both values of the bit command are applied over a known background, so a wrong index or an update of a neighbouring bit shows up. Further checks cover writes and reads with select high, and a reset in the middle of the run.

// File: rtl/tri_port_pio_pkg.sv
package tri_port_pio_pkg;
  localparam int PORT_W = 8;
  localparam int HALF_W = PORT_W / 2;
  localparam int SEL_W  = $clog2(PORT_W);

  // bit positions inside a direction word
  localparam int FMT_BIT   = 7;
  localparam int DIR_A_BIT = 4;
  localparam int DIR_CU_BIT = 3;
  localparam int DIR_B_BIT = 1;
  localparam int DIR_CL_BIT = 0;

  // command readback after reset: every port an input
  localparam logic [PORT_W-1:0] MODE_RST = 8'h9B;

  typedef enum logic [1:0] {
    SEL_A    = 2'd0,
    SEL_B    = 2'd1,
    SEL_C    = 2'd2,
    SEL_CTRL = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic     wrA;
    logic     wrB;
    logic     wrC;
    logic     wrMode;
    logic     wrBit;
    logic     rdEn;
    reg_sel_e rdSel;
  } strobe_t;
endpackage

// File: rtl/tri_port_pio_ctrl.sv
module tri_port_pio_ctrl
  import tri_port_pio_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              csN,
  input  logic              rdN,
  input  logic              wrN,
  input  logic [1:0]        addr,
  input  logic [PORT_W-1:0] dataIn,
  output strobe_t           strb
);
  logic wrActive;
  logic rdActive;
  reg_sel_e sel;

  assign sel      = reg_sel_e'(addr);
  assign wrActive = !csN && !wrN;
  assign rdActive = !csN && !rdN && wrN;

  always_comb begin
    strb        = '0;
    strb.rdEn   = rdActive;
    strb.rdSel  = sel;
    if (wrActive) begin
      unique case (sel)
        SEL_A:    strb.wrA = 1'b1;
        SEL_B:    strb.wrB = 1'b1;
        SEL_C:    strb.wrC = 1'b1;
        SEL_CTRL: begin
          strb.wrMode = dataIn[FMT_BIT];
          strb.wrBit  = !dataIn[FMT_BIT];
        end
        default: ;
      endcase
    end
  end

  // R2: at most one write target per cycle
  assert_one_target_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strb.wrA, strb.wrB, strb.wrC, strb.wrMode, strb.wrBit}));

  // R3: a deselected block neither writes nor reads
  assert_cs_gate_R3: assert property (@(posedge clk) disable iff (rst)
    csN |-> !(strb.rdEn || strb.wrA || strb.wrB || strb.wrC || strb.wrMode || strb.wrBit));
endmodule

// File: rtl/tri_port_pio_dp.sv
module tri_port_pio_dp
  import tri_port_pio_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           strb,
  input  logic [PORT_W-1:0] dataIn,
  input  logic [PORT_W-1:0] paIn,
  input  logic [PORT_W-1:0] pbIn,
  input  logic [PORT_W-1:0] pcIn,
  output logic [PORT_W-1:0] paOut,
  output logic [PORT_W-1:0] pbOut,
  output logic [PORT_W-1:0] pcOut,
  output logic [PORT_W-1:0] paOe,
  output logic [PORT_W-1:0] pbOe,
  output logic [PORT_W-1:0] pcOe,
  output logic [PORT_W-1:0] rdData
);
  logic [PORT_W-1:0] latA, latB, latC, modeReg;
  logic [SEL_W-1:0]  bitSel;
  logic              dirA, dirB;
  logic [1:0]        dirC;      // [1] upper nibble, [0] lower nibble
  logic [PORT_W-1:0] rdC;
  logic              anyWr;

  assign bitSel = dataIn[SEL_W:1];
  assign dirA   = modeReg[DIR_A_BIT];
  assign dirB   = modeReg[DIR_B_BIT];
  assign dirC   = {modeReg[DIR_CU_BIT], modeReg[DIR_CL_BIT]};
  assign anyWr  = strb.wrA || strb.wrB || strb.wrC || strb.wrMode || strb.wrBit;

  always_ff @(posedge clk) begin
    if (rst) begin
      modeReg <= MODE_RST;
      latA    <= '0;
      latB    <= '0;
      latC    <= '0;
    end else begin
      if (strb.wrMode) begin
        modeReg <= dataIn;
        latA    <= '0;
        latB    <= '0;
        latC    <= '0;
      end
      if (strb.wrA) latA <= dataIn;
      if (strb.wrB) latB <= dataIn;
      if (strb.wrC) latC <= dataIn;
      if (strb.wrBit) begin
        for (int i = 0; i < PORT_W; i++) begin
          if (bitSel == SEL_W'(i)) latC[i] <= dataIn[0];
        end
      end
    end
  end

  assign paOut = latA;
  assign pbOut = latB;
  assign pcOut = latC;
  assign paOe  = {PORT_W{!dirA}};
  assign pbOe  = {PORT_W{!dirB}};

  // port C: each nibble resolves direction and readback on its own
  for (genvar h = 0; h < 2; h++) begin : g_cHalf
    assign pcOe[h*HALF_W +: HALF_W] = {HALF_W{!dirC[h]}};
    assign rdC[h*HALF_W +: HALF_W]  = dirC[h] ? pcIn[h*HALF_W +: HALF_W]
                                              : latC[h*HALF_W +: HALF_W];
  end

  always_comb begin
    unique case (strb.rdSel)
      SEL_A:    rdData = dirA ? paIn : latA;
      SEL_B:    rdData = dirB ? pbIn : latB;
      SEL_C:    rdData = rdC;
      SEL_CTRL: rdData = modeReg;
      default:  rdData = '0;
    endcase
  end

  // R1: reset leaves every port listening
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (modeReg == MODE_RST && latA == '0 && latB == '0 && latC == '0));

  // R5: a direction word empties all latches
  assert_mode_clears_R5: assert property (@(posedge clk) disable iff (rst)
    strb.wrMode |=> (latA == '0 && latB == '0 && latC == '0));

  // R6: bit command keeps the direction word and lands on the chosen bit
  assert_bit_keeps_mode_R6: assert property (@(posedge clk) disable iff (rst)
    strb.wrBit |=> $stable(modeReg));
  assert_bit_target_R6: assert property (@(posedge clk) disable iff (rst)
    strb.wrBit |=> (latC[$past(bitSel)] == $past(dataIn[0])));

  // R3: without a write strobe nothing stored may move
  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !anyWr |=> ($stable(latA) && $stable(latB) && $stable(latC) && $stable(modeReg)));
endmodule

// File: rtl/tri_port_pio.sv
module tri_port_pio
  import tri_port_pio_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       csN,
  input  logic       rdN,
  input  logic       wrN,
  input  logic [1:0] addr,
  input  logic [7:0] dataIn,
  output logic [7:0] dataOut,
  output logic       dataOe,
  output logic [7:0] paOut,
  output logic [7:0] paOe,
  input  logic [7:0] paIn,
  output logic [7:0] pbOut,
  output logic [7:0] pbOe,
  input  logic [7:0] pbIn,
  output logic [7:0] pcOut,
  output logic [7:0] pcOe,
  input  logic [7:0] pcIn
);
  strobe_t strb;

  tri_port_pio_ctrl u_ctrl (
    .clk(clk), .rst(rst), .csN(csN), .rdN(rdN), .wrN(wrN),
    .addr(addr), .dataIn(dataIn), .strb(strb)
  );

  tri_port_pio_dp u_dp (
    .clk(clk), .rst(rst), .strb(strb), .dataIn(dataIn),
    .paIn(paIn), .pbIn(pbIn), .pcIn(pcIn),
    .paOut(paOut), .pbOut(pbOut), .pcOut(pcOut),
    .paOe(paOe), .pbOe(pbOe), .pcOe(pcOe),
    .rdData(dataOut)
  );

  assign dataOe = strb.rdEn;
endmodule

// File: tb/tri_port_pio_test.sv
module tri_port_pio_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic csN = 1'b1, rdN = 1'b1, wrN = 1'b1;
  logic [1:0] addr = '0;
  logic [7:0] dataIn = '0;
  logic [7:0] paIn = '0, pbIn = '0, pcIn = '0;
  logic [7:0] dataOut, paOut, paOe, pbOut, pbOe, pcOut, pcOe;
  logic dataOe;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  // bench model
  logic [7:0] mA, mB, mC, mW;

  always #2 clk = ~clk;   // 250 MHz

  tri_port_pio uut (
    .clk(clk), .rst(rst), .csN(csN), .rdN(rdN), .wrN(wrN), .addr(addr),
    .dataIn(dataIn), .dataOut(dataOut), .dataOe(dataOe),
    .paOut(paOut), .paOe(paOe), .paIn(paIn),
    .pbOut(pbOut), .pbOe(pbOe), .pbIn(pbIn),
    .pcOut(pcOut), .pcOe(pcOe), .pcIn(pcIn)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic busWr(input logic selN, input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    csN = selN; wrN = 1'b0; addr = a; dataIn = d;
    @(negedge clk);
    wrN = 1'b1; csN = 1'b1;
  endtask

  task automatic busRd(input logic selN, input logic [1:0] a,
                       output logic [7:0] d, output logic oe);
    @(negedge clk);
    csN = selN; rdN = 1'b0; addr = a;
    #1;
    d = dataOut; oe = dataOe;
    rdN = 1'b1; csN = 1'b1;
  endtask

  function automatic logic [7:0] expRead(input logic [1:0] a);
    case (a)
      2'd0: return mW[4] ? paIn : mA;
      2'd1: return mW[1] ? pbIn : mB;
      2'd2: return {mW[3] ? pcIn[7:4] : mC[7:4], mW[0] ? pcIn[3:0] : mC[3:0]};
      default: return mW;
    endcase
  endfunction

  function automatic logic [23:0] expOe();
    return {{8{!mW[4]}}, {8{!mW[1]}}, {{4{!mW[3]}}, {4{!mW[0]}}}};
  endfunction

  task automatic modeWr(input logic [7:0] w);
    busWr(1'b0, 2'd3, w);
    mW = w; mA = '0; mB = '0; mC = '0;
  endtask

  task automatic checkAll(input string tag);
    logic [7:0] d;
    logic oe;
    check({tag, " oe"}, {paOe, pbOe, pcOe}, expOe());
    check({tag, " out"}, {paOut, pbOut, pcOut}, {mA, mB, mC});
    for (int a = 0; a < 4; a++) begin
      busRd(1'b0, 2'(a), d, oe);
      check({tag, " read"}, {oe, d}, {1'b1, expRead(2'(a))});
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : stim
    logic [7:0] d;
    logic oe;
    mW = 8'h9B; mA = '0; mB = '0; mC = '0;
    repeat (3) @(negedge clk);
    // R1: state held in reset
    check("R1 oe in reset", {paOe, pbOe, pcOe}, 24'h0);
    check("R1 latches in reset", {paOut, pbOut, pcOut}, 24'h0);
    rst = 1'b0;
    paIn = 8'hC3; pbIn = 8'h3C; pcIn = 8'hA5;
    busRd(1'b0, 2'd3, d, oe);
    check("R1 ctrl readback", {oe, d}, {1'b1, 8'h9B});
    checkAll("R1 R7 post-reset");

    // R4 named control words
    modeWr(8'h80); check("R4 80h", {paOe, pbOe, pcOe}, 24'hFFFFFF);
    modeWr(8'h82); check("R4 82h", {paOe, pbOe, pcOe}, 24'hFF00FF);
    modeWr(8'h83); check("R4 83h", {paOe, pbOe, pcOe}, 24'hFF00F0);
    modeWr(8'h90); check("R4 90h", {paOe, pbOe, pcOe}, 24'h00FFFF);

    // sweep every direction word: R2 R4 R5 R7 R8 R9
    for (int m = 0; m < 128; m++) begin
      logic [7:0] w;
      w = 8'h80 | 8'(m);
      busWr(1'b0, 2'd0, 8'h11);
      busWr(1'b0, 2'd2, 8'h22);
      modeWr(w);
      paIn = 8'(m * 7 + 3); pbIn = 8'(m * 13 + 9); pcIn = ~8'(m * 5);
      checkAll((w[6] | w[5] | w[2]) ? "R9 R4 R5 R8 after mode" : "R4 R5 R8 after mode");
      busWr(1'b0, 2'd0, 8'(m ^ 8'h5A)); mA = 8'(m ^ 8'h5A);
      busWr(1'b0, 2'd1, 8'(m + 8'h81)); mB = 8'(m + 8'h81);
      busWr(1'b0, 2'd2, 8'(~m ^ 8'h0F)); mC = 8'(~m ^ 8'h0F);
      checkAll((w[6] | w[5] | w[2]) ? "R9 R2 R7 ports" : "R2 R7 ports");
    end

    // R6: bit commands over a known background
    modeWr(8'h80);
    busWr(1'b0, 2'd2, 8'h5A); mC = 8'h5A;
    for (int i = 0; i < 8; i++) begin
      for (int v = 0; v < 2; v++) begin
        logic [7:0] cmd;
        cmd = {1'b0, 3'(i * 3), 3'(i), 1'(v)};
        busWr(1'b0, 2'd3, cmd);
        mC[i] = 1'(v);
        check("R6 bit cmd pcOut", pcOut, mC);
        check("R6 other ports", {paOut, pbOut, paOe}, {mA, mB, 8'hFF});
        busRd(1'b0, 2'd3, d, oe);
        check("R6 R8 readback kept", d, 8'h80);
      end
    end

    // R3: deselected accesses
    busWr(1'b1, 2'd0, 8'hEE);
    busWr(1'b1, 2'd2, 8'hDD);
    busWr(1'b1, 2'd3, 8'h9B);
    busWr(1'b1, 2'd3, 8'h01);
    check("R3 cs high writes", {paOut, pbOut, pcOut, paOe}, {mA, mB, mC, 8'hFF});
    busRd(1'b1, 2'd3, d, oe);
    check("R3 cs high read oe", oe, 1'b0);
    @(negedge clk); csN = 1'b0; rdN = 1'b0; wrN = 1'b0; addr = 2'd0; dataIn = mA; #1;
    check("R3 oe low during write", dataOe, 1'b0);
    wrN = 1'b1; rdN = 1'b1; csN = 1'b1;

    // R1: reset in mid-run
    busWr(1'b0, 2'd1, 8'h77);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    mW = 8'h9B; mA = '0; mB = '0; mC = '0;
    checkAll("R1 mid-run reset");

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule